// File: doc/BRIEF.md
# Partitioned Floating-Point Status Register with Replay Detection

This block keeps floating-point status and control state in three separate registers, so that floating-point operations can issue without waiting on each other's status output. The first register is the per-result volatile part: the rounded flag, the inexact flag and the result-class field. The second is the sticky part, which holds the accumulating exception flags. The third is the control part, which holds the remaining state, including the rounding mode. When an operation issues, it reads the sticky and control values directly from the registers. The block records that sticky value against the operation's tag. The value is not forwarded from older in-flight operations.

Operations complete in program order, one per cycle at most. On completion the block commits the operation's volatile result and ORs its newly raised exceptions into the sticky register. It then compares the resulting sticky value with the value recorded at issue. If the two differ, the speculation was wrong, and the block raises a one-cycle flush pulse. The pulse carries the tag of the oldest younger operation, so that the pipeline can cancel and re-issue everything after the completing operation. An explicit write to the control part also commits in order, and it always flushes younger work. A build-time option adds the control part to the comparison.

Top module: `fps_status_part`

## Requirements
- R1: After reset, the volatile, sticky and control outputs are zero, and no flush is signalled.
- R2: An operation that issues (`iss_valid`) records the sticky value shown on `stk_o` in that cycle, keyed by `iss_tag`. Later completions of that tag compare against this record. Slots that have not been written since reset hold zero.
- R3: An operation completion (`cmp_valid` high, `cmp_ctl_wr` low) sets `vol_o` to `cmp_vol` in the next cycle. `cmp_vol` is packed as {rounded flag [6], inexact flag [5], result class [4:0]}.
- R4: An operation completion sets `stk_o` to the previous `stk_o` OR `cmp_exc` in the next cycle.
- R5: An operation completion leaves `ctl_o` unchanged. A control write (`cmp_valid` and `cmp_ctl_wr`) loads `cmp_ctl` into `ctl_o` and leaves `vol_o` and `stk_o` unchanged.
- R6: When an operation's new sticky value differs from its recorded issue value, `flush_valid` is high for the cycle after completion. In that cycle `flush_tag` equals `cmp_tag`+1, modulo 2^TAG_W.
- R7: When an operation's new sticky value equals its recorded issue value, and no other flush cause applies, `flush_valid` stays low.
- R8: A control write raises `flush_valid` in the next cycle, with `flush_tag` equal to `cmp_tag`+1, modulo 2^TAG_W.
- R9: With `TRACK_CTL`=0, a control value that differs between issue and completion causes no flush. With `TRACK_CTL`=1, the block also records the control value at issue, and a difference at an operation's completion raises a flush as in R6.
- R10: `flush_valid` is low in any cycle that does not follow a completion.
- R11: `rmode_o` equals `ctl_o[1:0]`, encoded as 0 = nearest, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An operation issues this cycle |
| iss_tag | input | TAG_W | Tag of the issuing operation |
| cmp_valid | input | 1 | The oldest operation completes this cycle |
| cmp_ctl_wr | input | 1 | The completion is an explicit control write |
| cmp_tag | input | TAG_W | Tag of the completing operation |
| cmp_vol | input | VOL_W | Volatile result of an operation completion |
| cmp_exc | input | STK_W | Exceptions newly raised by the operation |
| cmp_ctl | input | CTL_W | New control value for a control write |
| vol_o | output | VOL_W | Volatile register |
| stk_o | output | STK_W | Sticky register; also the issue-time sticky view |
| ctl_o | output | CTL_W | Control register; also the issue-time control view |
| rmode_o | output | 2 | Rounding-mode field of the control register |
| flush_valid | output | 1 | One-cycle request to cancel younger operations |
| flush_tag | output | TAG_W | Tag of the oldest operation to cancel |

## Verification
The bench goes after the cases that speculation makes hard. In the first, an operation raises a flag that is already set, which must not flush; a design that compared raised bits instead of the merged value would replay on every exception. In the second, an operation issues in the same cycle as an older completion that changes the sticky value; a design that recorded the post-update value would miss the replay. In the third, the tag wraps from the top value to zero; a wrong flush tag would cancel the wrong operation. A second instance built with control tracking checks that a control change made between issue and completion flushes there and only there. A design that ignored the build option would disagree with the default instance on exactly those steps.

// File: rtl/fps_pkg.sv
package fps_pkg;
    parameter int TAG_W = 3;
    parameter int STK_W = 8;
    parameter int CTL_W = 8;
    parameter int CLS_W = 5;
    localparam int VOL_W = CLS_W + 2;
    localparam int SLOTS = 1 << TAG_W;

    typedef logic [TAG_W-1:0] tag_t;

    typedef struct packed {
        logic             rnd;
        logic             inx;
        logic [CLS_W-1:0] cls;
    } vol_t;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_ZERO    = 2'd1,
        RM_UP      = 2'd2,
        RM_DOWN    = 2'd3
    } rmode_e;

    function automatic tag_t tag_after(tag_t t);
        return t + tag_t'(1);
    endfunction

    function automatic rmode_e ctl_rmode(logic [CTL_W-1:0] c);
        return rmode_e'(c[1:0]);
    endfunction
endpackage

// File: rtl/fps_state.sv
module fps_state
    import fps_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             op_commit,
    input  logic             ctl_commit,
    input  vol_t             vol_in,
    input  logic [STK_W-1:0] exc_in,
    input  logic [CTL_W-1:0] ctl_in,
    output vol_t             vol_q,
    output logic [STK_W-1:0] stk_q,
    output logic [CTL_W-1:0] ctl_q,
    output logic [STK_W-1:0] stk_merged
);
    assign stk_merged = stk_q | exc_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            vol_q <= '0;
            stk_q <= '0;
            ctl_q <= '0;
        end else begin
            if (op_commit) begin
                vol_q <= vol_in;
                stk_q <= stk_merged;
            end
            if (ctl_commit) begin
                ctl_q <= ctl_in;
            end
        end
    end
endmodule

// File: rtl/fps_snap.sv
module fps_snap
    import fps_pkg::*;
#(
    parameter bit TRACK_CTL = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  tag_t             wr_tag,
    input  logic [STK_W-1:0] stk_in,
    input  logic [CTL_W-1:0] ctl_in,
    input  tag_t             rd_tag,
    output logic [STK_W-1:0] stk_out,
    output logic [CTL_W-1:0] ctl_out
);
    logic [STK_W-1:0] stk_tab [SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) stk_tab[i] <= '0;
        end else if (wr_en) begin
            stk_tab[wr_tag] <= stk_in;
        end
    end
    assign stk_out = stk_tab[rd_tag];

    generate
        if (TRACK_CTL) begin : g_ctl
            logic [CTL_W-1:0] ctl_tab [SLOTS];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < SLOTS; i++) ctl_tab[i] <= '0;
                end else if (wr_en) begin
                    ctl_tab[wr_tag] <= ctl_in;
                end
            end
            assign ctl_out = ctl_tab[rd_tag];
        end else begin : g_noctl
            assign ctl_out = ctl_in;
        end
    endgenerate
endmodule

// File: rtl/fps_cmp.sv
module fps_cmp
    import fps_pkg::*;
#(
    parameter bit TRACK_CTL = 1'b0
) (
    input  logic [STK_W-1:0] stk_new,
    input  logic [STK_W-1:0] stk_snap,
    input  logic [CTL_W-1:0] ctl_cur,
    input  logic [CTL_W-1:0] ctl_snap,
    output logic             mismatch
);
    logic stk_diff;
    assign stk_diff = (stk_new != stk_snap);

    generate
        if (TRACK_CTL) begin : g_track
            assign mismatch = stk_diff || (ctl_cur != ctl_snap);
        end else begin : g_plain
            assign mismatch = stk_diff;
        end
    endgenerate
endmodule

// File: rtl/fps_status_part.sv
module fps_status_part
    import fps_pkg::*;
#(
    parameter bit TRACK_CTL = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             iss_valid,
    input  logic [TAG_W-1:0] iss_tag,
    input  logic             cmp_valid,
    input  logic             cmp_ctl_wr,
    input  logic [TAG_W-1:0] cmp_tag,
    input  logic [VOL_W-1:0] cmp_vol,
    input  logic [STK_W-1:0] cmp_exc,
    input  logic [CTL_W-1:0] cmp_ctl,
    output logic [VOL_W-1:0] vol_o,
    output logic [STK_W-1:0] stk_o,
    output logic [CTL_W-1:0] ctl_o,
    output logic [1:0]       rmode_o,
    output logic             flush_valid,
    output logic [TAG_W-1:0] flush_tag
);
    logic             op_commit, ctl_commit, mismatch, flush_d;
    vol_t             vol_q;
    logic [STK_W-1:0] stk_q, stk_merged, stk_snap;
    logic [CTL_W-1:0] ctl_q, ctl_snap;

    assign op_commit  = cmp_valid && !cmp_ctl_wr;
    assign ctl_commit = cmp_valid && cmp_ctl_wr;

    fps_state u_state (
        .clk        (clk),
        .rst        (rst),
        .op_commit  (op_commit),
        .ctl_commit (ctl_commit),
        .vol_in     (vol_t'(cmp_vol)),
        .exc_in     (cmp_exc),
        .ctl_in     (cmp_ctl),
        .vol_q      (vol_q),
        .stk_q      (stk_q),
        .ctl_q      (ctl_q),
        .stk_merged (stk_merged)
    );

    fps_snap #(.TRACK_CTL(TRACK_CTL)) u_snap (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (iss_valid),
        .wr_tag  (iss_tag),
        .stk_in  (stk_q),
        .ctl_in  (ctl_q),
        .rd_tag  (cmp_tag),
        .stk_out (stk_snap),
        .ctl_out (ctl_snap)
    );

    fps_cmp #(.TRACK_CTL(TRACK_CTL)) u_cmp (
        .stk_new  (stk_merged),
        .stk_snap (stk_snap),
        .ctl_cur  (ctl_q),
        .ctl_snap (ctl_snap),
        .mismatch (mismatch)
    );

    assign flush_d = ctl_commit || (op_commit && mismatch);

    always_ff @(posedge clk) begin
        if (rst) begin
            flush_valid <= 1'b0;
            flush_tag   <= '0;
        end else begin
            flush_valid <= flush_d;
            flush_tag   <= flush_d ? tag_after(cmp_tag) : '0;
        end
    end

    assign vol_o   = vol_q;
    assign stk_o   = stk_q;
    assign ctl_o   = ctl_q;
    assign rmode_o = ctl_rmode(ctl_q);
endmodule

module fps_chk
    import fps_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cmp_valid,
    input logic             cmp_ctl_wr,
    input logic [TAG_W-1:0] cmp_tag,
    input logic [VOL_W-1:0] cmp_vol,
    input logic [STK_W-1:0] cmp_exc,
    input logic [CTL_W-1:0] cmp_ctl,
    input logic [VOL_W-1:0] vol_o,
    input logic [STK_W-1:0] stk_o,
    input logic [CTL_W-1:0] ctl_o,
    input logic             flush_valid,
    input logic [TAG_W-1:0] flush_tag
);
    // R3
    vol_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && !cmp_ctl_wr) |=> vol_o == $past(cmp_vol));

    // R4
    stk_merge_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && !cmp_ctl_wr) |=> stk_o == ($past(stk_o) | $past(cmp_exc)));

    // R5
    ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && !cmp_ctl_wr) |=> $stable(ctl_o));

    // R5
    ctl_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_ctl_wr) |=> (ctl_o == $past(cmp_ctl)) && $stable(stk_o));

    // R8
    ctl_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_ctl_wr) |=>
            flush_valid && (flush_tag == TAG_W'($past(cmp_tag) + 1'b1)));

    // R10
    idle_noflush_chk: assert property (@(posedge clk) disable iff (rst)
        !cmp_valid |=> !flush_valid);
endmodule

bind fps_status_part fps_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmp_valid  (cmp_valid),
    .cmp_ctl_wr (cmp_ctl_wr),
    .cmp_tag    (cmp_tag),
    .cmp_vol    (cmp_vol),
    .cmp_exc    (cmp_exc),
    .cmp_ctl    (cmp_ctl),
    .vol_o      (vol_o),
    .stk_o      (stk_o),
    .ctl_o      (ctl_o),
    .flush_valid(flush_valid),
    .flush_tag  (flush_tag)
);

// File: tb/sim_fps_status_part.sv
module sim_fps_status_part;
    import fps_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int RAND_STEPS = 600;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic iss_valid = 1'b0, cmp_valid = 1'b0, cmp_ctl_wr = 1'b0;
    logic [TAG_W-1:0] iss_tag = '0, cmp_tag = '0;
    logic [VOL_W-1:0] cmp_vol = '0;
    logic [STK_W-1:0] cmp_exc = '0;
    logic [CTL_W-1:0] cmp_ctl = '0;
    logic [VOL_W-1:0] vol0, vol1;
    logic [STK_W-1:0] stk0, stk1;
    logic [CTL_W-1:0] ctl0, ctl1;
    logic [1:0] rm0, rm1;
    logic fv0, fv1;
    logic [TAG_W-1:0] ft0, ft1;

    int checks = 0, errors = 0;

    // model state
    logic [VOL_W-1:0] m_vol;
    logic [STK_W-1:0] m_stk;
    logic [CTL_W-1:0] m_ctl;
    logic [STK_W-1:0] m_sstk [SLOTS];
    logic [CTL_W-1:0] m_sctl [SLOTS];
    logic m_fv0, m_fv1;
    logic [TAG_W-1:0] m_ft;

    always #(CLK_PERIOD/2) clk = ~clk;

    fps_status_part #(.TRACK_CTL(1'b0)) u0 (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_tag(iss_tag),
        .cmp_valid(cmp_valid), .cmp_ctl_wr(cmp_ctl_wr), .cmp_tag(cmp_tag),
        .cmp_vol(cmp_vol), .cmp_exc(cmp_exc), .cmp_ctl(cmp_ctl),
        .vol_o(vol0), .stk_o(stk0), .ctl_o(ctl0), .rmode_o(rm0),
        .flush_valid(fv0), .flush_tag(ft0));

    fps_status_part #(.TRACK_CTL(1'b1)) u1 (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_tag(iss_tag),
        .cmp_valid(cmp_valid), .cmp_ctl_wr(cmp_ctl_wr), .cmp_tag(cmp_tag),
        .cmp_vol(cmp_vol), .cmp_exc(cmp_exc), .cmp_ctl(cmp_ctl),
        .vol_o(vol1), .stk_o(stk1), .ctl_o(ctl1), .rmode_o(rm1),
        .flush_valid(fv1), .flush_tag(ft1));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [TAG_W-1:0] exp_next_tag(logic [TAG_W-1:0] t);
        return (t == TAG_W'(SLOTS - 1)) ? '0 : t + 1'b1;
    endfunction

    task automatic model_reset();
        m_vol = '0; m_stk = '0; m_ctl = '0;
        m_fv0 = 1'b0; m_fv1 = 1'b0; m_ft = '0;
        for (int i = 0; i < SLOTS; i++) begin
            m_sstk[i] = '0;
            m_sctl[i] = '0;
        end
    endtask

    // compares outputs with the model, at the negedge
    task automatic check_outputs();
        chk("R3 vol", vol0, m_vol);
        chk("R4 stk", stk0, m_stk);
        chk("R5 ctl", ctl0, m_ctl);
        chk("R11 rmode", rm0, m_ctl[1:0]);
        chk("R6 flush_valid default", fv0, m_fv0);
        chk("R9 flush_valid tracked", fv1, m_fv1);
        if (m_fv0) chk("R6 flush_tag", ft0, m_ft);
        if (m_fv1) chk("R9 flush_tag tracked", ft1, m_ft);
        chk("R9 tracked stk agrees", stk1, m_stk);
    endtask

    // drives one cycle of stimulus at the negedge, predicts, advances to next negedge
    task automatic step(input logic iv, input logic [TAG_W-1:0] it,
                        input logic cv, input logic cw, input logic [TAG_W-1:0] ct,
                        input logic [VOL_W-1:0] vv, input logic [STK_W-1:0] ev,
                        input logic [CTL_W-1:0] cc);
        logic [STK_W-1:0] nstk;
        logic [STK_W-1:0] sn_s;
        logic [CTL_W-1:0] sn_c;
        iss_valid = iv; iss_tag = it; cmp_valid = cv; cmp_ctl_wr = cw;
        cmp_tag = ct; cmp_vol = vv; cmp_exc = ev; cmp_ctl = cc;
        sn_s = m_sstk[ct];
        sn_c = m_sctl[ct];
        m_fv0 = 1'b0; m_fv1 = 1'b0; m_ft = exp_next_tag(ct);
        // R2: record register values visible now, before this edge's commit
        if (iv) begin
            m_sstk[it] = m_stk;
            m_sctl[it] = m_ctl;
        end
        if (cv && cw) begin
            m_ctl = cc;
            m_fv0 = 1'b1; m_fv1 = 1'b1;
        end else if (cv) begin
            nstk = m_stk | ev;
            m_fv0 = (nstk != sn_s);
            m_fv1 = m_fv0 || (m_ctl != sn_c);
            m_vol = vv;
            m_stk = nstk;
        end
        @(negedge clk);
        iss_valid = 1'b0; cmp_valid = 1'b0; cmp_ctl_wr = 1'b0;
        check_outputs();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 vol", vol0, '0);
        chk("R1 stk", stk0, '0);
        chk("R1 ctl", ctl0, '0);
        chk("R1 flush", fv0, 1'b0);
        chk("R1 flush tracked", fv1, 1'b0);

        // R7: clean op, no exceptions
        step(1, 3'd0, 0, 0, 3'd0, '0, '0, '0);
        step(0, 3'd0, 1, 0, 3'd0, 7'h45, '0, '0);
        chk("R7 no flush", fv0, 1'b0);
        // R6: new exception, flush tag 2
        step(1, 3'd1, 0, 0, 3'd0, '0, '0, '0);
        step(1, 3'd2, 1, 0, 3'd1, 7'h12, 8'h04, '0);
        chk("R6 flush raised", fv0, 1'b1);
        chk("R6 flush tag", ft0, 3'd2);
        // R2: tag2 issued same cycle as the change, recorded old 0, so it replays
        step(0, 3'd0, 1, 0, 3'd2, 7'h01, '0, '0);
        chk("R2 stale record flushes", fv0, 1'b1);
        // R7: already-set flag raised again, tag3 issued after change
        step(1, 3'd3, 0, 0, 3'd0, '0, '0, '0);
        step(0, 3'd0, 1, 0, 3'd3, 7'h02, 8'h04, '0);
        chk("R7 repeat flag no flush", fv0, 1'b0);
        // R8: control write at top tag wraps to 0, R11 rmode
        step(0, 3'd0, 1, 1, 3'd7, 7'h7f, 8'hff, 8'h03);
        chk("R8 flush", fv0, 1'b1);
        chk("R8 wrap tag", ft0, 3'd0);
        chk("R11 toward -inf", rm0, 2'd3);
        chk("R5 stk untouched by ctl write", stk0, 8'h04);
        // R9: issue with ctl=3, change ctl, complete without sticky change
        step(1, 3'd4, 0, 0, 3'd0, '0, '0, '0);
        step(0, 3'd0, 1, 1, 3'd2, '0, '0, 8'h01);
        step(0, 3'd0, 1, 0, 3'd4, 7'h03, '0, '0);
        chk("R9 default no ctl flush", fv0, 1'b0);
        chk("R9 tracked ctl flush", fv1, 1'b1);
        // R10 idle
        step(0, 3'd0, 0, 0, 3'd0, '0, '0, '0);
        chk("R10 idle", fv0, 1'b0);

        // random phase
        for (int n = 0; n < RAND_STEPS; n++) begin
            logic iv, cv, cw;
            logic [TAG_W-1:0] it, ct;
            logic [STK_W-1:0] ev;
            iv = ($urandom % 2) == 0;
            cv = ($urandom % 3) != 0;
            cw = ($urandom % 10) == 0;
            it = TAG_W'($urandom);
            ct = TAG_W'($urandom);
            ev = (($urandom % 6) == 0) ? STK_W'(1 << ($urandom % STK_W)) : '0;
            step(iv, it, cv, cw, ct, VOL_W'($urandom), ev, CTL_W'($urandom));
            if (($urandom % 150) == 0) begin
                rst = 1'b1;
                model_reset();
                @(negedge clk);
                rst = 1'b0;
                check_outputs();
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule